// File: doc/BRIEF.md
# Parallel Peripheral Interface Adapter

This block connects a processor bus to two 8-bit general-purpose peripheral ports, A and B. Each port has three registers: a direction register, an output register and a control register. Each port also has a pair of control lines. The first line of each pair is always an edge-sensitive input. The second line can be an edge-sensitive input or a control output. The processor reaches the registers through three chip-select inputs, a two-bit register select, a read/write line and a one-cycle access strobe. All of these are sampled on a single clock.

The second control line can run handshakes without software help. On port A, a read of the port pulls the line low until the peer answers with an edge on the first line. On port B, a write of the port starts the same sequence. A pulse variant drives the line low for a fixed number of cycles instead of waiting for the peer. Edges on the control lines set per-port flags. The flags can be masked, and they drive two active-low interrupt request outputs. After reset is released, the block ignores the bus for a parameterised number of cycles.

Top module: `pia_core`

## Requirements
- R1: Bit i of a port's direction register sets pin i as an output (1) or an input (0). `pa_dir`/`pb_dir` show the direction register and `pa_out`/`pb_out` show the output register.
- R2: Register select 0 reaches port A and 2 reaches port B. Through these addresses, the data/output register is reached when control bit 2 of that port is 1, and the direction register when it is 0. Register select 1 is control A and 3 is control B.
- R3: An access takes effect only in a cycle where `bus_stb`=1, `cs0`=1, `cs1`=1 and `cs2_n`=0. In every other cycle, `rdata_oe` is 0, `rdata` is 0 and no register changes.
- R4: A read of a port's data register returns the output register for bits set as outputs and the live pin for bits set as inputs.
- R5: Control bit 1 selects the active edge of the first line: 1 means rising, 0 means falling. An active edge sets flag bit 7. When control bit 0 is 1, the flag pulls the port's interrupt output low.
- R6: When control bit 5 is 0, the second line is an input. Bit 4 selects its active edge (1 means rising). Bit 3 enables its interrupt, and an active edge sets flag bit 6.
- R7: With control bits 5..3 = 100 on port A, the edge that completes a read of port A's data register drives `ca2_out` low. The next active edge of `ca1` drives it high again.
- R8: With control bits 5..3 = 100 on port B, a write of port B's data register drives `cb2_out` low. A read of port B's data register does not. The next active edge of `cb1` drives it high again.
- R9: With control bits 5..3 = 101, the same trigger drives the second line low for exactly PULSE_CYC cycles.
- R10: With control bits 5..4 = 11, the second line follows control bit 3. Its enable output (`ca2_oe`/`cb2_oe`) equals control bit 5.
- R11: A read of a port's data register clears both of that port's flags. An edge in the same cycle as the read still sets its flag. A read of the control register clears nothing.
- R12: Reset clears every register. All pins become inputs, the outputs read 0, both interrupt outputs are high and the second lines are inputs.
- R13: Accesses in the first HOLDOFF_CYC cycles after reset is released are ignored. During these cycles `rdata_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs0 | input | 1 | Chip select, active high |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| reg_sel | input | 2 | Register select |
| rd_wr | input | 1 | 1 = read, 0 = write |
| bus_stb | input | 1 | One-cycle access strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, 0 when not driven |
| rdata_oe | output | 1 | Read data is valid/driven |
| pa_in | input | DATA_W | Port A pin levels |
| pa_out | output | DATA_W | Port A output register |
| pa_dir | output | DATA_W | Port A direction (1 = output) |
| pb_in | input | DATA_W | Port B pin levels |
| pb_out | output | DATA_W | Port B output register |
| pb_dir | output | DATA_W | Port B direction (1 = output) |
| ca1 | input | 1 | Port A first control line |
| ca2_in | input | 1 | Port A second control line, input level |
| ca2_out | output | 1 | Port A second control line, output level |
| ca2_oe | output | 1 | Port A second control line drives |
| cb1 | input | 1 | Port B first control line |
| cb2_in | input | 1 | Port B second control line, input level |
| cb2_out | output | 1 | Port B second control line, output level |
| cb2_oe | output | 1 | Port B second control line drives |
| irqa_n | output | 1 | Port A interrupt request, active low |
| irqb_n | output | 1 | Port B interrupt request, active low |

## Verification
A wrong edge-history bit, flag or strobe state shows up at the ports one clock after the stimulus. It appears as an interrupt output that is wrongly low or high, a flag bit in the control readback, or a second-line level, and the bench samples each of these at the following falling clock edge. A stale direction or output register appears at the pin outputs and in the mixed readback as soon as a random pin pattern is applied. A miscounted pulse or hold-off counter changes a measured cycle count by at least one, which the bench compares with the parameter directly.

// File: rtl/pia_pkg.sv
package pia_pkg;

   localparam int CTL_W = 8;

   // Control register layout, bit 7 down to bit 0
   typedef struct packed {
      logic flag1;      // 7: first-line event (read only)
      logic flag2;      // 6: second-line event (read only)
      logic l2_drive;   // 5: second line is an output
      logic l2_b4;      // 4: input: rising edge / output: manual level mode
      logic l2_b3;      // 3: input: irq enable / output: pulse or manual level
      logic data_sel;   // 2: 1 = data register, 0 = direction register
      logic l1_rise;    // 1: first line active on rising edge
      logic l1_irq_en;  // 0: first-line irq enable
   } ctl_t;

   typedef enum logic [1:0] {
      L2_INPUT     = 2'd0,
      L2_HANDSHAKE = 2'd1,
      L2_PULSE     = 2'd2,
      L2_MANUAL    = 2'd3
   } l2_mode_e;

   function automatic l2_mode_e l2_mode_of(ctl_t c);
      l2_mode_e m;
      if (!c.l2_drive)  m = L2_INPUT;
      else if (c.l2_b4) m = L2_MANUAL;
      else if (c.l2_b3) m = L2_PULSE;
      else              m = L2_HANDSHAKE;
      return m;
   endfunction

endpackage

// File: rtl/pia_bus_decode.sv
module pia_bus_decode #(
   parameter int HOLDOFF_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs0,
   input  logic cs1,
   input  logic cs2_n,
   input  logic rd_wr,
   input  logic bus_stb,
   output logic acc_rd,
   output logic acc_wr
);

   if (HOLDOFF_CYC < 0) begin : g_bad_hold
      $error("HOLDOFF_CYC must not be negative");
   end

   logic ready;
   logic selected;

   assign selected = cs0 && cs1 && !cs2_n && bus_stb;

   if (HOLDOFF_CYC == 0) begin : g_no_hold
      assign ready = 1'b1;
   end else begin : g_hold
      localparam int HW = $clog2(HOLDOFF_CYC + 1);
      logic [HW-1:0] hold_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                hold_cnt <= HW'(HOLDOFF_CYC);
         else if (hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
      end
      assign ready = (hold_cnt == '0);

      AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         hold_cnt <= HW'(HOLDOFF_CYC));  // R13
   end

   assign acc_rd = selected && ready && rd_wr;
   assign acc_wr = selected && ready && !rd_wr;

   AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_rd && acc_wr));  // R3

endmodule

// File: rtl/pia_port.sv
module pia_port
   import pia_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int PULSE_CYC     = 2,
   parameter bit TRIG_ON_WRITE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_rd,
   input  logic              acc_wr,
   input  logic              sel_ctl,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] pin_in,
   input  logic              l1_in,
   input  logic              l2_in,
   output logic [DATA_W-1:0] rd_val,
   output logic [DATA_W-1:0] port_out,
   output logic [DATA_W-1:0] port_dir,
   output logic              l2_out,
   output logic              l2_oe,
   output logic              irq
);

   if (DATA_W < CTL_W) begin : g_bad_width
      $error("DATA_W must be at least the control register width");
   end
   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("PULSE_CYC must be at least 1");
   end

   localparam int PW = $clog2(PULSE_CYC + 1);

   logic [5:0]        ctl_lo;
   logic              flag1_q, flag2_q;
   logic [DATA_W-1:0] ddr_q, or_q;
   logic              l1_prev, l2_prev;
   logic              strobe_low;
   logic [PW-1:0]     pulse_cnt;
   ctl_t              ctl;
   l2_mode_e          mode;
   logic              data_rd, data_wr, dir_wr, ctl_wr;
   logic              l1_edge, l2_edge, trig;

   assign ctl  = {flag1_q, flag2_q, ctl_lo};
   assign mode = l2_mode_of(ctl);

   assign data_rd = acc_rd && !sel_ctl &&  ctl.data_sel;
   assign data_wr = acc_wr && !sel_ctl &&  ctl.data_sel;
   assign dir_wr  = acc_wr && !sel_ctl && !ctl.data_sel;
   assign ctl_wr  = acc_wr &&  sel_ctl;

   assign l1_edge = ctl.l1_rise ? (l1_in && !l1_prev) : (!l1_in && l1_prev);
   assign l2_edge = ctl.l2_b4   ? (l2_in && !l2_prev) : (!l2_in && l2_prev);

   if (TRIG_ON_WRITE) begin : g_wr_trig
      assign trig = data_wr;
   end else begin : g_rd_trig
      assign trig = data_rd;
   end

   // registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_lo  <= '0;
         ddr_q   <= '0;
         or_q    <= '0;
         l1_prev <= 1'b0;
         l2_prev <= 1'b0;
      end else begin
         l1_prev <= l1_in;
         l2_prev <= l2_in;
         if (ctl_wr)  ctl_lo <= wdata[5:0];
         if (dir_wr)  ddr_q  <= wdata;
         if (data_wr) or_q   <= wdata;
      end
   end

   // event flags: a new edge wins over a clearing read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag1_q <= 1'b0;
         flag2_q <= 1'b0;
      end else begin
         if (l1_edge)                     flag1_q <= 1'b1;
         else if (data_rd)                flag1_q <= 1'b0;
         if (l2_edge && mode == L2_INPUT) flag2_q <= 1'b1;
         else if (data_rd)                flag2_q <= 1'b0;
      end
   end

   // second-line strobe sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_low <= 1'b0;
         pulse_cnt  <= '0;
      end else begin
         if (mode != L2_HANDSHAKE) strobe_low <= 1'b0;
         else if (trig)            strobe_low <= 1'b1;
         else if (l1_edge)         strobe_low <= 1'b0;

         if (mode == L2_PULSE && trig) pulse_cnt <= PW'(PULSE_CYC);
         else if (pulse_cnt != '0)     pulse_cnt <= pulse_cnt - 1'b1;
      end
   end

   always_comb begin
      unique case (mode)
         L2_INPUT:     l2_out = 1'b1;
         L2_HANDSHAKE: l2_out = !strobe_low;
         L2_PULSE:     l2_out = (pulse_cnt == '0);
         default:      l2_out = ctl.l2_b3;
      endcase
   end

   assign l2_oe    = ctl.l2_drive;
   assign port_out = or_q;
   assign port_dir = ddr_q;
   assign irq      = (flag1_q && ctl.l1_irq_en) ||
                     (flag2_q && ctl.l2_b3 && !ctl.l2_drive);

   always_comb begin
      if (sel_ctl)           rd_val = DATA_W'(ctl);
      else if (ctl.data_sel) rd_val = (or_q & ddr_q) | (pin_in & ~ddr_q);
      else                   rd_val = ddr_q;
   end

   AST_HS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode == L2_HANDSHAKE) && mode == L2_HANDSHAKE &&
       $rose(flag1_q) && !$past(trig)) |-> !strobe_low);  // R7

   AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_cnt <= PW'(PULSE_CYC));  // R9

   AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !l1_edge) |=> !flag1_q);  // R11

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag1_q || flag2_q));  // R5

endmodule

// File: rtl/pia_core.sv
module pia_core #(
   parameter int DATA_W      = 8,
   parameter int HOLDOFF_CYC = 16,
   parameter int PULSE_CYC   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs0,
   input  logic              cs1,
   input  logic              cs2_n,
   input  logic [1:0]        reg_sel,
   input  logic              rd_wr,
   input  logic              bus_stb,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe,
   input  logic [DATA_W-1:0] pa_in,
   output logic [DATA_W-1:0] pa_out,
   output logic [DATA_W-1:0] pa_dir,
   input  logic [DATA_W-1:0] pb_in,
   output logic [DATA_W-1:0] pb_out,
   output logic [DATA_W-1:0] pb_dir,
   input  logic              ca1,
   input  logic              ca2_in,
   output logic              ca2_out,
   output logic              ca2_oe,
   input  logic              cb1,
   input  logic              cb2_in,
   output logic              cb2_out,
   output logic              cb2_oe,
   output logic              irqa_n,
   output logic              irqb_n
);

   logic              acc_rd, acc_wr;
   logic [DATA_W-1:0] rd_a, rd_b;
   logic              irq_a, irq_b;
   logic              hit_b;

   assign hit_b = reg_sel[1];

   pia_bus_decode #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_dec (
      .clk(clk), .rst_n(rst_n), .cs0(cs0), .cs1(cs1), .cs2_n(cs2_n),
      .rd_wr(rd_wr), .bus_stb(bus_stb), .acc_rd(acc_rd), .acc_wr(acc_wr)
   );

   pia_port #(.DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC), .TRIG_ON_WRITE(1'b0)) u_port_a (
      .clk(clk), .rst_n(rst_n),
      .acc_rd(acc_rd && !hit_b), .acc_wr(acc_wr && !hit_b),
      .sel_ctl(reg_sel[0]), .wdata(wdata), .pin_in(pa_in),
      .l1_in(ca1), .l2_in(ca2_in), .rd_val(rd_a),
      .port_out(pa_out), .port_dir(pa_dir),
      .l2_out(ca2_out), .l2_oe(ca2_oe), .irq(irq_a)
   );

   pia_port #(.DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC), .TRIG_ON_WRITE(1'b1)) u_port_b (
      .clk(clk), .rst_n(rst_n),
      .acc_rd(acc_rd && hit_b), .acc_wr(acc_wr && hit_b),
      .sel_ctl(reg_sel[0]), .wdata(wdata), .pin_in(pb_in),
      .l1_in(cb1), .l2_in(cb2_in), .rd_val(rd_b),
      .port_out(pb_out), .port_dir(pb_dir),
      .l2_out(cb2_out), .l2_oe(cb2_oe), .irq(irq_b)
   );

   assign rdata_oe = acc_rd;
   assign rdata    = !acc_rd ? '0 : (hit_b ? rd_b : rd_a);
   assign irqa_n   = !irq_a;
   assign irqb_n   = !irq_b;

   AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> (cs0 && cs1 && !cs2_n && bus_stb && rd_wr));  // R3

   AST_NO_WRITE_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs0 && cs1 && !cs2_n && bus_stb) |=> ($stable(pa_out) && $stable(pb_out)));  // R3

endmodule

// File: tb/tb_pia_core.sv
module tb_pia_core;

   localparam int W     = 8;
   localparam int HOLD  = 6;
   localparam int PULSE = 3;

   logic         clk = 0, rst_n = 0;
   logic         cs0 = 0, cs1 = 0, cs2_n = 1, rd_wr = 1, bus_stb = 0;
   logic [1:0]   reg_sel = 0;
   logic [W-1:0] wdata = 0, pa_in = 0, pb_in = 0;
   logic         ca1 = 0, ca2_in = 0, cb1 = 0, cb2_in = 0;
   logic [W-1:0] rdata, pa_out, pa_dir, pb_out, pb_dir;
   logic         rdata_oe, ca2_out, ca2_oe, cb2_out, cb2_oe, irqa_n, irqb_n;

   int checks = 0, fails = 0;

   always #2 clk = ~clk;

   pia_core #(.DATA_W(W), .HOLDOFF_CYC(HOLD), .PULSE_CYC(PULSE)) dut (
      .clk(clk), .rst_n(rst_n), .cs0(cs0), .cs1(cs1), .cs2_n(cs2_n),
      .reg_sel(reg_sel), .rd_wr(rd_wr), .bus_stb(bus_stb), .wdata(wdata),
      .rdata(rdata), .rdata_oe(rdata_oe), .pa_in(pa_in), .pa_out(pa_out),
      .pa_dir(pa_dir), .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir),
      .ca1(ca1), .ca2_in(ca2_in), .ca2_out(ca2_out), .ca2_oe(ca2_oe),
      .cb1(cb1), .cb2_in(cb2_in), .cb2_out(cb2_out), .cb2_oe(cb2_oe),
      .irqa_n(irqa_n), .irqb_n(irqb_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // cs = {cs0, cs1, cs2_n}; returns sampled read data and enable
   task automatic acc(input logic rw, input logic [1:0] rs, input logic [W-1:0] wd,
                      input logic [2:0] cs, output logic [W-1:0] rd, output logic oe);
      @(negedge clk);
      {cs0, cs1, cs2_n} = cs; rd_wr = rw; reg_sel = rs; wdata = wd; bus_stb = 1;
      #1; rd = rdata; oe = rdata_oe;
      @(negedge clk);
      bus_stb = 0; {cs0, cs1, cs2_n} = 3'b001;
   endtask

   task automatic wr(input logic [1:0] rs, input logic [W-1:0] wd);
      logic [W-1:0] d; logic o;
      acc(1'b0, rs, wd, 3'b110, d, o);
   endtask

   task automatic rd(input logic [1:0] rs, output logic [W-1:0] d);
      logic o;
      acc(1'b1, rs, '0, 3'b110, d, o);
   endtask

   task automatic step;
      @(negedge clk);
   endtask

   function automatic logic [W-1:0] mix(input logic [W-1:0] o, input logic [W-1:0] d,
                                        input logic [W-1:0] p);
      return (o & d) | (p & ~d);
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [W-1:0] d, ddr, orv, pin, prev_out;
      logic o;
      int n;
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      // R12 reset state
      chk("R12 pa_dir", pa_dir, 0);
      chk("R12 pa_out", pa_out, 0);
      chk("R12 pb_dir", pb_dir, 0);
      chk("R12 irq", {irqa_n, irqb_n}, 2'b11);
      chk("R12 line2 oe", {ca2_oe, cb2_oe}, 2'b00);
      chk("R12 line2 level", {ca2_out, cb2_out}, 2'b11);
      rst_n = 1;
      // R13 hold-off: accesses ignored
      acc(1'b1, 2'd1, '0, 3'b110, d, o);
      chk("R13 oe during holdoff", o, 0);
      wr(2'd1, 8'h3F);
      wr(2'd0, 8'hFF);
      repeat (HOLD + 2) step();
      acc(1'b1, 2'd1, '0, 3'b110, d, o);
      chk("R13 oe after holdoff", o, 1);
      chk("R13 ctrl A unchanged", d, 0);
      chk("R13 dir A unchanged", pa_dir, 0);

      // R2 address map
      wr(2'd1, 8'h00); wr(2'd0, 8'hA5);
      chk("R2 dir A written", pa_dir, 8'hA5);
      rd(2'd0, d); chk("R2 dir A readback", d, 8'hA5);
      wr(2'd1, 8'h04); wr(2'd0, 8'h3C);
      chk("R2 out A written", pa_out, 8'h3C);
      chk("R2 dir A kept", pa_dir, 8'hA5);
      rd(2'd1, d); chk("R2 ctrl A readback", d, 8'h04);
      wr(2'd3, 8'h00); wr(2'd2, 8'h0F); wr(2'd3, 8'h04); wr(2'd2, 8'hC3);
      chk("R2 dir B", pb_dir, 8'h0F);
      chk("R2 out B", pb_out, 8'hC3);

      // R3 bad selects
      for (int k = 0; k < 3; k++) begin
         logic [2:0] bad;
         bad = (k == 0) ? 3'b010 : (k == 1) ? 3'b100 : 3'b111;
         acc(1'b1, 2'd1, '0, bad, d, o);
         chk("R3 read unselected oe", o, 0);
         chk("R3 read unselected data", d, 0);
         acc(1'b0, 2'd0, 8'h99, bad, d, o);
         chk("R3 write unselected", pa_out, 8'h3C);
      end

      // R1/R4 random direction/output/pin patterns on both ports
      for (int it = 0; it < 40; it++) begin
         logic [1:0] base;
         base = ($urandom % 2) ? 2'd2 : 2'd0;
         ddr = W'($urandom); orv = W'($urandom); pin = W'($urandom);
         wr(base + 2'd1, 8'h00); wr(base, ddr);
         wr(base + 2'd1, 8'h04); wr(base, orv);
         if (base == 0) pa_in = pin; else pb_in = pin;
         if (($urandom % 4) == 0) begin
            prev_out = (base == 0) ? pa_out : pb_out;
            acc(1'b0, base, ~orv, 3'b111, d, o);
            chk("R3 random unselected write", (base == 0) ? pa_out : pb_out, prev_out);
         end
         rd(base, d);
         chk("R4 mixed readback", d, mix(orv, ddr, pin));
         chk("R1 direction", (base == 0) ? pa_dir : pb_dir, ddr);
         chk("R1 output", (base == 0) ? pa_out : pb_out, orv);
      end

      // R5 first-line edge, rising, irq enabled
      wr(2'd1, 8'h07);
      step(); ca1 = 1; step();
      chk("R5 irqa asserted", irqa_n, 0);
      rd(2'd1, d); chk("R5 flag bit7", d, 8'h87);
      rd(2'd1, d); chk("R11 ctrl read keeps flag", d, 8'h87);
      rd(2'd0, d);
      chk("R11 data read releases irq", irqa_n, 1);
      rd(2'd1, d); chk("R11 flag cleared", d, 8'h07);
      ca1 = 0; step(); step();
      chk("R5 inactive edge ignored", irqa_n, 1);
      // R5 masked
      wr(2'd1, 8'h06);
      ca1 = 1; step(); step();
      chk("R5 masked irq", irqa_n, 1);
      rd(2'd1, d); chk("R5 masked flag set", d, 8'h86);
      rd(2'd0, d); ca1 = 0; step();
      // R11 edge in same cycle as clearing read
      @(negedge clk);
      {cs0, cs1, cs2_n} = 3'b110; rd_wr = 1; reg_sel = 2'd0; bus_stb = 1; ca1 = 1;
      @(negedge clk);
      bus_stb = 0; {cs0, cs1, cs2_n} = 3'b001;
      rd(2'd1, d); chk("R11 edge wins over clear", d, 8'h86);
      rd(2'd0, d); ca1 = 0; step();

      // R6 second line as input, rising, irq enabled
      wr(2'd1, 8'h1C);
      ca2_in = 1; step(); step();
      chk("R6 irq from line2", irqa_n, 0);
      rd(2'd1, d); chk("R6 flag bit6", d, 8'h5C);
      rd(2'd0, d);
      chk("R6 cleared by data read", irqa_n, 1);
      ca2_in = 0; step();

      // R7 read handshake on port A
      wr(2'd1, 8'h24);
      chk("R10 oe in output mode", ca2_oe, 1);
      chk("R7 idle high", ca2_out, 1);
      rd(2'd0, d);
      chk("R7 low after read", ca2_out, 0);
      ca1 = 1; step(); step();
      chk("R7 inactive edge holds low", ca2_out, 0);
      ca1 = 0; step();
      chk("R7 released by active edge", ca2_out, 1);
      rd(2'd0, d); step();

      // R9 pulse on port A
      wr(2'd1, 8'h2C);
      rd(2'd0, d);
      n = 0;
      while (ca2_out == 0 && n < 10) begin n++; step(); end
      chk("R9 pulse width A", n, PULSE);

      // R10 manual level
      wr(2'd1, 8'h3C);
      chk("R10 manual high", {ca2_oe, ca2_out}, 2'b11);
      wr(2'd1, 8'h34);
      chk("R10 manual low", {ca2_oe, ca2_out}, 2'b10);
      wr(2'd1, 8'h14);
      chk("R10 back to input", ca2_oe, 0);

      // R8 write handshake on port B
      wr(2'd3, 8'h24);
      rd(2'd2, d);
      chk("R8 read does not trigger B", cb2_out, 1);
      wr(2'd2, 8'h55);
      chk("R8 low after write", cb2_out, 0);
      chk("R8 data written", pb_out, 8'h55);
      cb1 = 1; step(); step();
      chk("R8 inactive edge holds low", cb2_out, 0);
      cb1 = 0; step();
      chk("R8 released", cb2_out, 1);
      chk("R5 irqb masked", irqb_n, 1);
      rd(2'd3, d); chk("R8 flag on B", d, 8'hA4);

      // R9 pulse on port B
      wr(2'd3, 8'h2C);
      wr(2'd2, 8'h66);
      n = 0;
      while (cb2_out == 0 && n < 10) begin n++; step(); end
      chk("R9 pulse width B", n, PULSE);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule